// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Overrun Refusal

This block is the receive side of an I2C slave. It watches SCL and SDA as plain inputs and passes each line through a synchronizer and a minimum-phase filter. It recognises START and STOP, shifts bits in MSB first and compares the first byte of a transfer with a 7-bit device address held in a register. When the address matches with a write direction, the block acknowledges that byte and every data byte that follows it until the next START or STOP. It pulls SDA low on its own during the acknowledge bit. Each acknowledged byte, the address byte included, is moved into a holding buffer that software reads through a small register port.

Software services the block through three flags: buffer-full, overflow and interrupt. If a byte arrives while the previous one is still unread, or while an earlier overflow has not been cleared, the block refuses the byte. It gives no acknowledge and leaves the holding buffer untouched, but it still raises the overflow and interrupt flags. The master therefore sees a NACK, and software finds out why.

Register port (2-bit select): 0 = receive buffer (a read strobe clears buffer-full), 1 = status (bit 0 = buffer-full, other bits read 0), 2 = control flags (bit 6 = overflow, bit 7 = interrupt; a write clears each flag whose written bit is 0 and leaves it unchanged when the written bit is 1), 3 = own device address in bits 6:0.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset, sda_pull_low and irq are 0, the receive buffer, status and control registers read 0, and the own-address register reads the OWN_ADDR_RESET parameter.
- R2: An address byte whose first seven bits on the wire equal the own address and whose eighth bit (read/write) is 0 is acknowledged. sda_pull_low is held high from the SCL falling edge that ends bit 8 until the next SCL falling edge. An address byte that differs, or that has the read/write bit at 1, gets no acknowledge, and the block ignores the rest of the transfer until the next START.
- R3: Once addressed, every data byte is acknowledged when accepted. At the end of the ninth clock each accepted byte (address byte included) is placed in the receive buffer, status bit 0 is set and the interrupt flag (control bit 7, irq pin) is set.
- R4: A byte that completes while buffer-full is already set gets no acknowledge. The receive buffer keeps its old value, and overflow (control bit 6) and the interrupt flag are set.
- R5: A byte that completes while overflow is already set gets no acknowledge even when the buffer is empty, and the receive buffer is unchanged.
- R6: A read strobe on select 0 returns the buffer and clears buffer-full. Reads never clear overflow.
- R7: A write to select 2 clears overflow when bit 6 is 0 and clears the interrupt flag when bit 7 is 0. A 1 leaves the flag unchanged. The irq pin follows the interrupt flag.
- R8: START (SDA falling while SCL high) or STOP (SDA rising while SCL high) ends the addressed state, so the next byte is again treated as an address.
- R9: An SCL pulse shorter than MIN_PHASE system clocks is not taken as a clock edge.
- R10: Writing select 3 changes the address that R2 compares against.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_pull_low | output | 1 | 1 = drive SDA low (acknowledge) |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel |
| irq | output | 1 | Interrupt flag |

## Verification
A wrong bit count or a stale address-matched state shows up on sda_pull_low. The acknowledge then appears one SCL period early or late, or on a byte that should have been refused. This is visible within the same byte, a fixed number of system clocks after the SCL falling edge. A flag that fails to set or clear shows on the irq pin at the end of the ninth clock, and on the status and control reads that follow. A buffer that is overwritten on a refused byte shows up at the next read of select 0.

// File: rtl/i2c_rx_pkg.sv
// Shared constants and types for the I2C slave receive path.
// Assumes 8-bit bytes and 7-bit device addresses, as the protocol fixes.
package i2c_rx_pkg;
    localparam int BYTE_W      = 8;
    localparam int DEV_ADDR_W  = 7;
    localparam int SEL_W       = 2;

    localparam logic [SEL_W-1:0] SEL_RXBUF  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_STATUS = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 2'd2;
    localparam logic [SEL_W-1:0] SEL_OWN    = 2'd3;

    localparam int STAT_FULL_POS = 0;
    localparam int CTRL_OVF_POS  = 6;
    localparam int CTRL_IRQ_POS  = 7;

    typedef enum logic [1:0] {
        LINK_IDLE,
        LINK_ADDR,
        LINK_DATA,
        LINK_SKIP
    } link_state_t;

    typedef struct packed {
        logic              valid;
        logic              accepted;
        logic [BYTE_W-1:0] data;
    } rx_evt_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Synchronizes one bus line into the clk domain and only accepts a new
// level once it has been seen unchanged for MIN_PHASE clocks.
// Assumes the line idles high. Both bus lines use the same instance type,
// so their edges keep their relative order.
module i2c_line_filter #(
    parameter int MIN_PHASE   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic                   level_q;
    logic                   level_d;

    // Metastability guard: shift the raw line through the sync chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
    end

    assign synced = sync_q[SYNC_STAGES-1];

    generate
        if (MIN_PHASE <= 1) begin : g_direct
            // No phase qualification: follow the synchronized line.
            always_ff @(posedge clk) begin
                if (!rst_n) level_q <= 1'b1;
                else        level_q <= synced;
            end
        end else begin : g_hold
            localparam int CNT_W = $clog2(MIN_PHASE);
            logic [CNT_W-1:0] run_q;

            // Count how long the line has differed; flip after MIN_PHASE clocks.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q   <= '0;
                    level_q <= 1'b1;
                end else if (synced == level_q) begin
                    run_q   <= '0;
                end else if (run_q == CNT_W'(MIN_PHASE - 1)) begin
                    level_q <= synced;
                    run_q   <= '0;
                end else begin
                    run_q   <= run_q + 1'b1;
                end
            end
        end
    endgenerate

    // Delayed copy of the qualified level for edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b1;
        else        level_d <= level_q;
    end

    assign level = level_q;
    assign rise  = level_q & ~level_d;
    assign fall  = ~level_q & level_d;
endmodule

// File: rtl/i2c_rx_engine.sv
// Bus-side protocol engine: START/STOP detection, bit counting, address
// compare, acknowledge drive and a one-cycle completed-byte event.
// Assumes filtered, edge-aligned SCL/SDA. The accept decision (room_ok)
// is taken at the SCL falling edge that ends bit 8. The event is issued
// at the falling edge that ends the ninth clock.
module i2c_rx_engine
    import i2c_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_lvl,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  sda_lvl,
    input  logic                  sda_rise,
    input  logic                  sda_fall,
    input  logic [DEV_ADDR_W-1:0] own_addr,
    input  logic                  room_ok,
    output logic                  ack_drive,
    output rx_evt_t               evt,
    output logic                  matched,
    output logic                  start_det,
    output logic                  stop_det
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    link_state_t       state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              in_ack;
    logic              ack_q;
    logic              ok_q;
    logic              receiving;
    logic              shift_en;
    logic              byte_end;
    logic              ack_end;
    logic              addr_hit;
    logic              claim;

    // Bus condition and phase decode from the filtered lines.
    always_comb begin
        start_det = sda_fall & scl_lvl;
        stop_det  = sda_rise & scl_lvl;
        receiving = (state == LINK_ADDR) || (state == LINK_DATA);
        shift_en  = receiving & scl_rise & ~in_ack & (bit_cnt != LAST_BIT);
        byte_end  = receiving & scl_fall & ~in_ack & (bit_cnt == LAST_BIT);
        ack_end   = receiving & scl_fall & in_ack;
        addr_hit  = (shreg[BYTE_W-1:1] == own_addr) & ~shreg[0];
        claim     = (state == LINK_DATA) | ((state == LINK_ADDR) & addr_hit);
    end

    // Link state, bit counter and acknowledge phase control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= LINK_IDLE;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            ack_q   <= 1'b0;
            ok_q    <= 1'b0;
        end else if (start_det) begin
            state   <= LINK_ADDR;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            ack_q   <= 1'b0;
        end else if (stop_det) begin
            state   <= LINK_IDLE;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            ack_q   <= 1'b0;
        end else if (shift_en) begin
            bit_cnt <= bit_cnt + 1'b1;
        end else if (byte_end) begin
            if (claim) begin
                in_ack <= 1'b1;
                ok_q   <= room_ok;
                ack_q  <= room_ok;
                if (state == LINK_ADDR) state <= LINK_DATA;
            end else begin
                state   <= LINK_SKIP;
                bit_cnt <= '0;
            end
        end else if (ack_end) begin
            in_ack  <= 1'b0;
            ack_q   <= 1'b0;
            bit_cnt <= '0;
        end
    end

    // Shift register: sample SDA on each qualified SCL rise, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= {shreg[BYTE_W-2:0], sda_lvl};
    end

    // Completed-byte event, one clock wide, at the end of the ninth clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt <= '0;
        end else begin
            evt.valid <= ack_end & ~start_det & ~stop_det;
            if (ack_end) begin
                evt.accepted <= ok_q;
                evt.data     <= shreg;
            end
        end
    end

    assign ack_drive = ack_q;
    assign matched   = (state == LINK_DATA);
endmodule

// File: rtl/i2c_rx_regs.sv
// Software-visible side: holding buffer, buffer-full, overflow and
// interrupt flags, own-address register and read multiplexer.
// Assumes at most one completed-byte event per clock. A flag set by an
// event wins over a software clear in the same clock.
module i2c_rx_regs
    import i2c_rx_pkg::*;
#(
    parameter logic [DEV_ADDR_W-1:0] OWN_ADDR_RESET = 7'h2A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  rx_evt_t               evt,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [BYTE_W-1:0]     reg_wdata,
    output logic [BYTE_W-1:0]     reg_rdata,
    output logic [DEV_ADDR_W-1:0] own_addr,
    output logic                  room_ok,
    output logic                  buf_full,
    output logic                  ovf,
    output logic                  irq_flag,
    output logic [BYTE_W-1:0]     rxbuf
);
    logic take;
    logic refuse;
    logic ctrl_wr;
    logic buf_rd;

    // Event and access strobes.
    always_comb begin
        take    = evt.valid & evt.accepted;
        refuse  = evt.valid & ~evt.accepted;
        ctrl_wr = reg_wr & (reg_sel == SEL_CTRL);
        buf_rd  = reg_rd & (reg_sel == SEL_RXBUF);
    end

    // Holding buffer: loaded only by an accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    rxbuf <= '0;
        else if (take) rxbuf <= evt.data;
    end

    // Buffer-full: set by a load, cleared by a buffer read.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_full <= 1'b0;
        else if (take)   buf_full <= 1'b1;
        else if (buf_rd) buf_full <= 1'b0;
    end

    // Overflow: set by a refused byte, cleared only by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (refuse)  ovf <= 1'b1;
        else if (ctrl_wr) ovf <= ovf & reg_wdata[CTRL_OVF_POS];
    end

    // Interrupt flag: set by any completed claimed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_flag <= 1'b0;
        else if (evt.valid) irq_flag <= 1'b1;
        else if (ctrl_wr)   irq_flag <= irq_flag & reg_wdata[CTRL_IRQ_POS];
    end

    // Own device address register.
    always_ff @(posedge clk) begin
        if (!rst_n)                            own_addr <= OWN_ADDR_RESET;
        else if (reg_wr && reg_sel == SEL_OWN) own_addr <= reg_wdata[DEV_ADDR_W-1:0];
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_RXBUF:  reg_rdata = rxbuf;
            SEL_STATUS: reg_rdata[STAT_FULL_POS] = buf_full;
            SEL_CTRL: begin
                reg_rdata[CTRL_OVF_POS] = ovf;
                reg_rdata[CTRL_IRQ_POS] = irq_flag;
            end
            default:    reg_rdata[DEV_ADDR_W-1:0] = own_addr;
        endcase
    end

    assign room_ok = ~buf_full & ~ovf;
endmodule

// File: rtl/i2c_rx_slave.sv
// Top of the I2C slave receive path: two line filters, the protocol
// engine and the register block. Assumes SCL and SDA arrive asynchronously
// and the board drives SDA as an open-drain line (sda_pull_low = 1 pulls low).
module i2c_rx_slave
    import i2c_rx_pkg::*;
#(
    parameter int                    MIN_PHASE      = 4,
    parameter logic [DEV_ADDR_W-1:0] OWN_ADDR_RESET = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq
);
    logic                  scl_lvl_w, scl_rise_w, scl_fall_w;
    logic                  sda_lvl_w, sda_rise_w, sda_fall_w;
    logic [DEV_ADDR_W-1:0] own_addr_w;
    logic                  room_ok_w;
    logic                  matched_w, start_w, stop_w;
    logic                  full_w, ovf_w;
    logic [BYTE_W-1:0]     rxbuf_w;
    rx_evt_t               evt_w;

    i2c_line_filter #(.MIN_PHASE(MIN_PHASE)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_in(scl_in),
        .level(scl_lvl_w), .rise(scl_rise_w), .fall(scl_fall_w)
    );

    i2c_line_filter #(.MIN_PHASE(MIN_PHASE)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_in(sda_in),
        .level(sda_lvl_w), .rise(sda_rise_w), .fall(sda_fall_w)
    );

    i2c_rx_engine u_engine (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl_w), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
        .sda_lvl(sda_lvl_w), .sda_rise(sda_rise_w), .sda_fall(sda_fall_w),
        .own_addr(own_addr_w), .room_ok(room_ok_w),
        .ack_drive(sda_pull_low), .evt(evt_w),
        .matched(matched_w), .start_det(start_w), .stop_det(stop_w)
    );

    i2c_rx_regs #(.OWN_ADDR_RESET(OWN_ADDR_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .evt(evt_w),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .own_addr(own_addr_w), .room_ok(room_ok_w),
        .buf_full(full_w), .ovf(ovf_w), .irq_flag(irq), .rxbuf(rxbuf_w)
    );
endmodule

// File: rtl/i2c_rx_slave_chk.sv
// Protocol and flag properties for i2c_rx_slave, attached by bind.
// Assumes the internal wire names of the top module listed in the bind.
module i2c_rx_slave_chk
    import i2c_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sda_pull_low,
    input logic              irq,
    input logic              scl_fall,
    input logic              start_det,
    input logic              stop_det,
    input logic              matched,
    input logic              buf_full,
    input logic              ovf,
    input logic [BYTE_W-1:0] rxbuf,
    input logic              reg_wr,
    input logic [SEL_W-1:0]  reg_sel
);
    // R2: the acknowledge starts on a qualified SCL falling edge.
    a_r2_ack_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> $past(scl_fall));

    // R2/R8: the acknowledge ends on SCL falling or on a bus condition.
    a_r2_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_low) |-> $past(scl_fall | start_det | stop_det));

    // R4: no acknowledge when the buffer was full at the decision.
    a_r4_no_ack_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !$past(buf_full));

    // R5: no acknowledge when overflow was pending at the decision.
    a_r5_no_ack_when_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !$past(ovf));

    // R4: a refused byte leaves the buffer untouched.
    a_r4_refuse_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $stable(rxbuf));

    // R3: loading the buffer raises the interrupt in the same clock.
    a_r3_load_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |-> irq);

    // R7: overflow only falls through a control write.
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(reg_wr && reg_sel == SEL_CTRL)) |=> ovf);

    // R8: STOP leaves the addressed state.
    a_r8_stop_unmatch: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !matched);
endmodule

bind i2c_rx_slave i2c_rx_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_pull_low(sda_pull_low), .irq(irq),
    .scl_fall(scl_fall_w), .start_det(start_w), .stop_det(stop_w),
    .matched(matched_w), .buf_full(full_w), .ovf(ovf_w), .rxbuf(rxbuf_w),
    .reg_wr(reg_wr), .reg_sel(reg_sel)
);

// File: tb/test_i2c_rx_slave.sv
`timescale 1ns/1ps
module test_i2c_rx_slave;
    localparam int         MINP  = 4;
    localparam logic [6:0] ADDR0 = 7'h2A;
    localparam int         T     = 16;        // quarter SCL period in clocks
    localparam int         L_ENG = MINP + 3;  // raw SCL edge -> ack pin
    localparam int         L_REG = MINP + 4;  // raw SCL edge -> flags

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic       sda_line;
    logic       sda_pull_low;
    logic       irq;
    logic [7:0] reg_rdata;

    assign sda_line = sda_m & ~sda_pull_low;

    i2c_rx_slave #(.MIN_PHASE(MINP), .OWN_ADDR_RESET(ADDR0)) i_i2c_rx_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull_low(sda_pull_low), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference model state
    bit         m_drive, m_irq, m_full, m_ovf;
    logic [7:0] m_buf;
    logic [6:0] m_own = ADDR0;
    int         m_state = 0;   // 0 idle, 1 expect address, 2 addressed, 3 ignoring
    int         q_due[$];
    int         q_kind[$];
    int         q_val[$];

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic sched(input int delay, input int kind, input int val);
        q_due.push_back(cyc + delay);
        q_kind.push_back(kind);
        q_val.push_back(val);
    endtask

    task automatic apply_evt(input int kind, input int val);
        case (kind)
            0: m_drive = val[0];
            1: begin m_buf = val[7:0]; m_full = 1; m_irq = 1; end
            2: begin m_ovf = 1; m_irq = 1; end
            3: m_full = 0;
            default: begin m_ovf = m_ovf & val[6]; m_irq = m_irq & val[7]; end
        endcase
    endtask

    // Per-clock comparison of the model with the pins
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int i = 0; i < q_due.size(); ) begin
                if (q_due[i] <= cyc) begin
                    apply_evt(q_kind[i], q_val[i]);
                    q_due.delete(i); q_kind.delete(i); q_val.delete(i);
                end else begin
                    i++;
                end
            end
            chk("R2", "sda_pull_low", {7'd0, sda_pull_low}, {7'd0, m_drive});
            chk("R7", "irq pin", {7'd0, irq}, {7'd0, m_irq});
        end
    end

    task automatic wait_c(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic sw_read(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        if (sel == 2'd0) sched(1, 3, 0);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = v;
        if (sel == 2'd2) sched(1, 4, v);
        if (sel == 2'd3) m_own = v[6:0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [1:0] sel, input logic [7:0] exp,
                            input string req, input string what);
        logic [7:0] d;
        sw_read(sel, d);
        chk(req, what, d, exp);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; m_state = 1;
        wait_c(2 * T);
        scl_m = 1'b0;
        wait_c(T);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wait_c(T);
        scl_m = 1'b1; wait_c(T);
        sda_m = 1'b0; m_state = 1; wait_c(T);
        scl_m = 1'b0; wait_c(T);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_c(T);
        scl_m = 1'b1; wait_c(T);
        sda_m = 1'b1; m_state = 0; wait_c(2 * T);
    endtask

    task automatic send_byte(input logic [7:0] b, input string req, input bit glitch);
        bit   claim = 0;
        bit   ok = 0;
        logic seen;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            wait_c(T);
            if (glitch && i == 3) begin
                scl_m = 1'b1; wait_c(MINP - 2);
                scl_m = 1'b0; wait_c(T);
            end
            scl_m = 1'b1; wait_c(2 * T);
            scl_m = 1'b0;
            if (i == 0) begin
                claim = (m_state == 2) || (m_state == 1 && b[7:1] == m_own && !b[0]);
                if (m_state == 1) m_state = claim ? 2 : 3;
                ok = claim && !m_full && !m_ovf;
                if (ok) sched(L_ENG, 0, 1);
            end
            wait_c(T);
        end
        sda_m = 1'b1; wait_c(T);
        scl_m = 1'b1; wait_c(T);
        seen = sda_pull_low;
        wait_c(T);
        scl_m = 1'b0;
        if (claim) begin
            if (ok) begin
                sched(L_ENG, 0, 0);
                sched(L_REG, 1, b);
            end else begin
                sched(L_REG, 2, 0);
            end
        end
        wait_c(T);
        chk(req, "ack seen in ninth clock", {7'd0, seen}, {7'd0, ok});
    endtask

    task automatic report();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        rst_n = 1'b0;
        wait_c(6);
        rst_n = 1'b1;
        wait_c(4);

        // R1: reset values
        read_chk(2'd1, 8'h00, "R1", "status after reset");
        read_chk(2'd2, 8'h00, "R1", "control after reset");
        read_chk(2'd3, {1'b0, ADDR0}, "R1", "own address after reset");
        read_chk(2'd0, 8'h00, "R1", "buffer after reset");

        // R2/R3: matching write address, then a data byte
        bus_start();
        send_byte({ADDR0, 1'b0}, "R2", 0);
        read_chk(2'd1, 8'h01, "R3", "full after address byte");
        read_chk(2'd2, 8'h80, "R3", "irq flag after address byte");
        read_chk(2'd0, {ADDR0, 1'b0}, "R3", "address byte in buffer");
        read_chk(2'd1, 8'h00, "R6", "full cleared by read");
        sw_write(2'd2, 8'h40);
        read_chk(2'd2, 8'h00, "R7", "irq cleared by write");
        send_byte(8'hA5, "R3", 0);
        read_chk(2'd0, 8'hA5, "R3", "data byte in buffer");
        sw_write(2'd2, 8'h00);

        // R4: unread byte, then a refused byte
        send_byte(8'h5A, "R3", 0);
        send_byte(8'hC3, "R4", 0);
        read_chk(2'd2, 8'hC0, "R4", "overflow and irq after refusal");
        read_chk(2'd0, 8'h5A, "R4", "buffer kept on refusal");
        read_chk(2'd1, 8'h00, "R6", "full cleared by read");

        // R5/R6/R7: pending overflow blocks an empty buffer
        send_byte(8'h77, "R5", 0);
        read_chk(2'd0, 8'h5A, "R5", "buffer kept under overflow");
        read_chk(2'd2, 8'hC0, "R6", "read leaves overflow set");
        sw_write(2'd2, 8'h80);
        read_chk(2'd2, 8'h80, "R7", "write clears only overflow");
        sw_write(2'd2, 8'h00);
        read_chk(2'd2, 8'h00, "R7", "write clears irq");
        send_byte(8'h99, "R3", 0);
        read_chk(2'd0, 8'h99, "R3", "accepted after clear");
        bus_stop();

        // R2: wrong address and the rest of the transfer ignored
        bus_start();
        send_byte(8'h99, "R2", 0);
        send_byte({ADDR0, 1'b0}, "R2", 0);
        read_chk(2'd1, 8'h00, "R2", "nothing loaded while ignoring");

        // R2: read direction is not claimed; R8 repeated start
        bus_rstart();
        send_byte({ADDR0, 1'b1}, "R2", 0);
        bus_rstart();
        send_byte({ADDR0, 1'b0}, "R8", 0);
        read_chk(2'd0, {ADDR0, 1'b0}, "R8", "address after repeated start");
        send_byte(8'h12, "R3", 0);
        read_chk(2'd0, 8'h12, "R3", "data after repeated start");
        bus_rstart();
        send_byte(8'h12, "R8", 0);
        bus_stop();
        bus_start();
        send_byte(8'h12, "R8", 0);
        bus_stop();
        sw_write(2'd2, 8'h00);

        // R10: new own address
        sw_write(2'd3, 8'h11);
        read_chk(2'd3, 8'h11, "R10", "own address written");
        bus_start();
        send_byte({ADDR0, 1'b0}, "R10", 0);
        bus_rstart();
        send_byte(8'h22, "R10", 0);
        read_chk(2'd0, 8'h22, "R10", "new address loaded");

        // R9: short SCL pulse inside a data byte
        send_byte(8'h6B, "R9", 1);
        read_chk(2'd0, 8'h6B, "R9", "byte intact despite glitch");
        bus_stop();
        wait_c(20);
        report();
    end
endmodule